// File: doc/BRIEF.md
# TLB Maintenance Write Trap Decoder

This block decides what happens when a core issues a 32-bit coprocessor-write instruction that asks for a TLB invalidation by virtual address across all address-space identifiers, limited to last-level entries, in the inner-shareable domain. It compares the instruction fields with the one encoding that names this operation. It then uses the current exception level, whether the hypervisor level is enabled, whether that level runs 32-bit or 64-bit code, and the hypervisor's trap-control bits to pick one outcome: no match, undefined, trap to a 64-bit hypervisor, trap to a 32-bit hypervisor, or execute.

A pipeline stage pulses `dec_valid` with the fields and the control state. One cycle later the block returns a registered one-hot outcome. On a trap it also returns the exception class code and the trap bit that caused it. On execute it returns the page-aligned virtual address taken from the source operand. The maintenance operation itself and the exception entry are handled elsewhere.

Top module: `tlbi_trap_decode`

## Requirements
- R1: The operation is recognised only when coprocessor number = 4'b1111, op1 = 3'b000, CRn = 4'b1000, CRm = 4'b0011 and op2 = 3'b111. Any other encoding gives outcome bit 4 (no match) alone, whatever the exception level and trap bits are.
- R2: A matching instruction at exception level 0 (`cur_el` = 0) gives outcome bit 3 (undefined).
- R3: At level 1 with the hypervisor enabled, the trap bits are checked in this fixed order: the coprocessor-register trap bit, then the TLB trap bit, then the inner-shareable TLB trap bit. The first bit that is set selects the trap. `res_cause` reports it as 1, 2 or 3 in that order, and as 0 on any outcome that is not a trap.
- R4: When `hyp_is32` = 0, only the 64-bit trap bits are used and a trap gives outcome bit 1. When `hyp_is32` = 1, only the 32-bit trap bits are used and a trap gives outcome bit 2. The inner-shareable bit for this case comes from the second hypervisor configuration register.
- R5: At level 1 the operation executes (outcome bit 0) when the hypervisor level is disabled, whatever the trap bits are. It also executes when no trap bit in the selected set is set.
- R6: At levels 2 and 3 a matching instruction always executes, whatever the trap bits are.
- R7: Every trap outcome reports `res_ec` = 6'h03. All other outcomes report 0.
- R8: The result appears one cycle after a `dec_valid` strobe, with `res_valid` high and exactly one outcome bit set. In a cycle that follows no strobe, `res_valid` and all outcome bits are 0.
- R9: On execute, `res_va` carries bits [31:12] of `src_val`. On any other outcome it is 0.
- R10: While reset is held and after it is released, all outputs are 0 until the first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | Decode strobe; fields and control state are sampled on it |
| cp_num | input | 4 | Coprocessor number field |
| op1 | input | 3 | First opcode field |
| crn | input | 4 | Primary register field |
| crm | input | 4 | Secondary register field |
| op2 | input | 3 | Second opcode field |
| cur_el | input | 2 | Current exception level, 0 to 3 |
| hyp_en | input | 1 | Hypervisor level enabled in the current security state |
| hyp_is32 | input | 1 | Hypervisor level runs 32-bit code |
| t64_cpreg | input | 1 | 64-bit coprocessor-register trap bit |
| t64_tlb | input | 1 | 64-bit TLB trap bit |
| t64_tlbis | input | 1 | 64-bit inner-shareable TLB trap bit |
| t32_cpreg | input | 1 | 32-bit coprocessor-register trap bit |
| t32_tlb | input | 1 | 32-bit TLB trap bit |
| t32_tlbis | input | 1 | 32-bit inner-shareable TLB trap bit (second configuration register) |
| src_val | input | 32 | Source register value |
| res_valid | output | 1 | Result valid, one cycle after the strobe |
| res_outcome | output | 5 | One-hot: bit0 execute, bit1 trap 64, bit2 trap 32, bit3 undefined, bit4 no match |
| res_cause | output | 2 | Trap bit that won: 0 none, 1 coprocessor-register, 2 TLB, 3 inner-shareable TLB |
| res_ec | output | 6 | Exception class code on a trap |
| res_va | output | 20 | Page-aligned virtual address on execute |

## Verification
The bench sets several trap bits at once to check the priority order. A design that reversed the order or merged the bits would report the wrong cause. It sets the trap bits of the set that is not in use and expects them to be ignored. A design that read the wrong register set would trap when it should execute, or trap to the wrong hypervisor width. It also sends encodings that differ from the match by a single field and sends a matching instruction at level 0 with trap bits set. A design that checked the encoding too late or gave level 0 the level 1 trap path would report execute or a trap in place of no match or undefined. Finally it holds the strobe low between decodes, so a result that stayed valid too long or arrived on the wrong cycle is caught.

// File: rtl/tlbi_trap_pkg.sv
// Shared constants for the TLB maintenance trap decoder.
// Assumes one-hot outcome positions are fixed and decoded by the consumer.
package tlbi_trap_pkg;
    localparam int OUT_W      = 5;
    localparam int OUT_EXEC   = 0;
    localparam int OUT_TRAP64 = 1;
    localparam int OUT_TRAP32 = 2;
    localparam int OUT_UNDEF  = 3;
    localparam int OUT_NOMAT  = 4;

    localparam logic [3:0] ENC_CP  = 4'b1111;
    localparam logic [2:0] ENC_OP1 = 3'b000;
    localparam logic [3:0] ENC_CRN = 4'b1000;
    localparam logic [3:0] ENC_CRM = 4'b0011;
    localparam logic [2:0] ENC_OP2 = 3'b111;

    localparam logic [1:0] EL_USER = 2'd0;
    localparam logic [1:0] EL_KERN = 2'd1;
endpackage

// File: rtl/tlbi_enc_match.sv
// Compares the instruction fields with the single encoding of the
// invalidate operation. Purely combinational; assumes stable fields.
module tlbi_enc_match
    import tlbi_trap_pkg::*;
(
    input  logic [3:0] cp_num,
    input  logic [2:0] op1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    output logic       hit
);
    // Field-by-field equality against the fixed encoding.
    always_comb begin
        hit = (cp_num == ENC_CP) && (op1 == ENC_OP1) && (crn == ENC_CRN)
           && (crm == ENC_CRM) && (op2 == ENC_OP2);
    end
endmodule

// File: rtl/tlbi_trap_chain.sv
// Picks the trap bit set for the hypervisor width and finds the first set
// bit in fixed priority order (index 0 highest). Returns its index plus one,
// or zero when none is set. Assumes bit order cpreg, tlb, tlbis.
module tlbi_trap_chain #(
    parameter int NUM_TRAP = 3,
    localparam int CW = $clog2(NUM_TRAP + 1)
) (
    input  logic                hyp_is32,
    input  logic [NUM_TRAP-1:0] bits64,
    input  logic [NUM_TRAP-1:0] bits32,
    output logic [CW-1:0]       cause
);
    logic [NUM_TRAP-1:0] sel;

    // Register-set choice driven by the hypervisor width.
    always_comb sel = hyp_is32 ? bits32 : bits64;

    // Find-first scan; later iterations at lower index override.
    always_comb begin
        cause = '0;
        for (int i = NUM_TRAP - 1; i >= 0; i--) begin
            if (sel[i]) cause = CW'(i + 1);
        end
    end
endmodule

// File: rtl/tlbi_trap_decode.sv
// Top of the TLB maintenance write trap decoder. Matches the encoding,
// applies level and hypervisor trap rules, and registers a one-hot outcome
// one cycle after dec_valid. Assumes inputs are stable around the clock edge.
module tlbi_trap_decode
    import tlbi_trap_pkg::*;
#(
    parameter int          VA_W    = 20,
    parameter int          SRC_W   = 32,
    parameter int          EC_W    = 6,
    parameter logic [5:0]  EC_TRAP = 6'h03,
    localparam int NUM_TRAP = 3,
    localparam int CW       = $clog2(NUM_TRAP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_valid,
    input  logic [3:0]       cp_num,
    input  logic [2:0]       op1,
    input  logic [3:0]       crn,
    input  logic [3:0]       crm,
    input  logic [2:0]       op2,
    input  logic [1:0]       cur_el,
    input  logic             hyp_en,
    input  logic             hyp_is32,
    input  logic             t64_cpreg,
    input  logic             t64_tlb,
    input  logic             t64_tlbis,
    input  logic             t32_cpreg,
    input  logic             t32_tlb,
    input  logic             t32_tlbis,
    input  logic [SRC_W-1:0] src_val,
    output logic             res_valid,
    output logic [OUT_W-1:0] res_outcome,
    output logic [CW-1:0]    res_cause,
    output logic [EC_W-1:0]  res_ec,
    output logic [VA_W-1:0]  res_va
);
    logic              enc_hit;
    logic [CW-1:0]     chain_cause;
    logic [OUT_W-1:0]  nxt_outcome;
    logic [CW-1:0]     nxt_cause;
    logic [EC_W-1:0]   nxt_ec;
    logic [VA_W-1:0]   nxt_va;
    logic              kern_trap;

    tlbi_enc_match u_match (
        .cp_num (cp_num),
        .op1    (op1),
        .crn    (crn),
        .crm    (crm),
        .op2    (op2),
        .hit    (enc_hit)
    );

    tlbi_trap_chain #(.NUM_TRAP(NUM_TRAP)) u_chain (
        .hyp_is32 (hyp_is32),
        .bits64   ({t64_tlbis, t64_tlb, t64_cpreg}),
        .bits32   ({t32_tlbis, t32_tlb, t32_cpreg}),
        .cause    (chain_cause)
    );

    // Trap is only possible at level 1 with the hypervisor enabled.
    always_comb kern_trap = (cur_el == EL_KERN) && hyp_en && (chain_cause != '0);

    // Outcome selection: encoding, then level 0, then trap, else execute.
    always_comb begin
        nxt_outcome = '0;
        nxt_cause   = '0;
        nxt_ec      = '0;
        nxt_va      = '0;
        if (!enc_hit) begin
            nxt_outcome[OUT_NOMAT] = 1'b1;
        end else if (cur_el == EL_USER) begin
            nxt_outcome[OUT_UNDEF] = 1'b1;
        end else if (kern_trap) begin
            nxt_outcome[hyp_is32 ? OUT_TRAP32 : OUT_TRAP64] = 1'b1;
            nxt_cause = chain_cause;
            nxt_ec    = EC_TRAP[EC_W-1:0];
        end else begin
            nxt_outcome[OUT_EXEC] = 1'b1;
            nxt_va = src_val[SRC_W-1 -: VA_W];
        end
    end

    // Result register; cleared when no strobe is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_outcome <= '0;
            res_cause   <= '0;
            res_ec      <= '0;
            res_va      <= '0;
        end else if (dec_valid) begin
            res_valid   <= 1'b1;
            res_outcome <= nxt_outcome;
            res_cause   <= nxt_cause;
            res_ec      <= nxt_ec;
            res_va      <= nxt_va;
        end else begin
            res_valid   <= 1'b0;
            res_outcome <= '0;
            res_cause   <= '0;
            res_ec      <= '0;
            res_va      <= '0;
        end
    end

    // R8: a valid result carries exactly one outcome bit.
    a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($countones(res_outcome) == 1));
    // R8: no result without a strobe one cycle earlier.
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |=> (!res_valid && res_outcome == '0));
    // R8: a strobe yields a valid result on the next cycle.
    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> res_valid);
    // R7: trap outcomes carry the fixed class code, others carry zero.
    a_r7_ec_code: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((res_outcome[OUT_TRAP64] || res_outcome[OUT_TRAP32])
                       ? (res_ec == EC_TRAP[EC_W-1:0]) : (res_ec == '0)));
    // R2: undefined only follows a level 0 decode.
    a_r2_undef_el0: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_outcome[OUT_UNDEF]) |-> ($past(cur_el) == EL_USER));
    // R6: a matching decode at level 2 or 3 always executes.
    a_r6_high_exec: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(cur_el) >= 2'd2 && !res_outcome[OUT_NOMAT])
        |-> res_outcome[OUT_EXEC]);
    // R3: cause is nonzero exactly on trap outcomes.
    a_r3_cause_trap: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((res_cause != '0) ==
                       (res_outcome[OUT_TRAP64] || res_outcome[OUT_TRAP32])));
endmodule

// File: tb/tb_tlbi_trap_decode.sv
`timescale 1ns/1ps
module tb_tlbi_trap_decode;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_valid = 1'b0;
    logic [3:0]  cp_num = '0;
    logic [2:0]  op1 = '0;
    logic [3:0]  crn = '0;
    logic [3:0]  crm = '0;
    logic [2:0]  op2 = '0;
    logic [1:0]  cur_el = '0;
    logic        hyp_en = 1'b0, hyp_is32 = 1'b0;
    logic        t64_cpreg = 1'b0, t64_tlb = 1'b0, t64_tlbis = 1'b0;
    logic        t32_cpreg = 1'b0, t32_tlb = 1'b0, t32_tlbis = 1'b0;
    logic [31:0] src_val = '0;
    logic        res_valid;
    logic [4:0]  res_outcome;
    logic [1:0]  res_cause;
    logic [5:0]  res_ec;
    logic [19:0] res_va;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    tlbi_trap_decode dut (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid),
        .cp_num(cp_num), .op1(op1), .crn(crn), .crm(crm), .op2(op2),
        .cur_el(cur_el), .hyp_en(hyp_en), .hyp_is32(hyp_is32),
        .t64_cpreg(t64_cpreg), .t64_tlb(t64_tlb), .t64_tlbis(t64_tlbis),
        .t32_cpreg(t32_cpreg), .t32_tlb(t32_tlb), .t32_tlbis(t32_tlbis),
        .src_val(src_val), .res_valid(res_valid), .res_outcome(res_outcome),
        .res_cause(res_cause), .res_ec(res_ec), .res_va(res_va)
    );

    // Expected {valid, outcome, cause, ec, va} from the requirements.
    function automatic logic [33:0] model(input logic v);
        logic [4:0]  oc = '0;
        logic [1:0]  ca = '0;
        logic [5:0]  ec = '0;
        logic [19:0] va = '0;
        logic [2:0]  b;
        if (!v) return '0;
        b = hyp_is32 ? {t32_cpreg, t32_tlb, t32_tlbis} : {t64_cpreg, t64_tlb, t64_tlbis};
        if (!(cp_num == 4'hF && op1 == 3'd0 && crn == 4'h8 && crm == 4'h3 && op2 == 3'd7))
            oc[4] = 1'b1;
        else if (cur_el == 2'd0)
            oc[3] = 1'b1;
        else if (cur_el == 2'd1 && hyp_en && b != 3'b000) begin
            ca = b[2] ? 2'd1 : (b[1] ? 2'd2 : 2'd3);
            oc[hyp_is32 ? 2 : 1] = 1'b1;
            ec = 6'h03;
        end else begin
            oc[0] = 1'b1;
            va = src_val[31:12];
        end
        return {1'b1, oc, ca, ec, va};
    endfunction

    task automatic compare(input string req, input logic [33:0] exp);
        logic [33:0] got = {res_valid, res_outcome, res_cause, res_ec, res_va};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got v=%b oc=%b ca=%0d ec=%h va=%h exp v=%b oc=%b ca=%0d ec=%h va=%h",
                     req, got[33], got[32:28], got[27:26], got[25:20], got[19:0],
                     exp[33], exp[32:28], exp[27:26], exp[25:20], exp[19:0]);
        end
    endtask

    task automatic set_match();
        cp_num = 4'hF; op1 = 3'd0; crn = 4'h8; crm = 4'h3; op2 = 3'd7;
    endtask

    task automatic set_ctl(input logic [1:0] el, input logic en, input logic w32,
                           input logic [2:0] b64, input logic [2:0] b32);
        cur_el = el; hyp_en = en; hyp_is32 = w32;
        {t64_cpreg, t64_tlb, t64_tlbis} = b64;
        {t32_cpreg, t32_tlb, t32_tlbis} = b32;
    endtask

    // Strobe once at a falling edge; check at the next falling edge.
    task automatic decode(input string req);
        logic [33:0] exp;
        @(negedge clk);
        dec_valid = 1'b1;
        exp = model(1'b1);
        @(negedge clk);
        dec_valid = 1'b0;
        compare(req, exp);
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog: got hang expected completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        // R10: reset state
        repeat (3) @(negedge clk);
        compare("R10 in reset", '0);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R10 after reset", '0);

        src_val = 32'hDEAD_BEEF;
        // R1: single-field mismatches at level 1 with traps set
        set_ctl(2'd1, 1'b1, 1'b0, 3'b111, 3'b111);
        set_match(); op2 = 3'd6;   decode("R1 op2");
        set_match(); crm = 4'h7;   decode("R1 crm");
        set_match(); cp_num = 4'hE; decode("R1 cp");
        set_match(); cur_el = 2'd0; crn = 4'h7; decode("R1 el0 mismatch");
        // R2: level 0 undefined, trap bits set
        set_match(); set_ctl(2'd0, 1'b1, 1'b0, 3'b111, 3'b111); decode("R2 el0");
        // R3: priority, 64-bit
        set_ctl(2'd1, 1'b1, 1'b0, 3'b111, 3'b000); decode("R3 all set cause1");
        set_ctl(2'd1, 1'b1, 1'b0, 3'b011, 3'b000); decode("R3 tlb over tlbis");
        set_ctl(2'd1, 1'b1, 1'b0, 3'b001, 3'b000); decode("R3 tlbis only");
        // R4: 32-bit set, other set ignored
        set_ctl(2'd1, 1'b1, 1'b1, 3'b000, 3'b001); decode("R4 32 tlbis");
        set_ctl(2'd1, 1'b1, 1'b1, 3'b000, 3'b110); decode("R4 32 cpreg");
        set_ctl(2'd1, 1'b1, 1'b1, 3'b111, 3'b000); decode("R4 64 bits ignored");
        set_ctl(2'd1, 1'b1, 1'b0, 3'b000, 3'b111); decode("R4 32 bits ignored");
        // R5: hypervisor disabled, traps ignored
        set_ctl(2'd1, 1'b0, 1'b0, 3'b111, 3'b111); decode("R5 hyp off");
        // R6: high levels
        set_ctl(2'd2, 1'b1, 1'b1, 3'b111, 3'b111); decode("R6 el2");
        src_val = 32'h0000_1FFF;
        set_ctl(2'd3, 1'b1, 1'b0, 3'b111, 3'b111); decode("R6 R9 el3");
        // R8: gap with no strobe
        @(negedge clk); compare("R8 no strobe", '0);
        // R8: back-to-back strobes
        @(negedge clk);
        dec_valid = 1'b1;
        set_ctl(2'd1, 1'b1, 1'b0, 3'b100, 3'b000);
        begin
            logic [33:0] e1;
            e1 = model(1'b1);
            @(negedge clk);
            compare("R8 b2b first", e1);
            set_ctl(2'd2, 1'b0, 1'b0, 3'b000, 3'b000);
            e1 = model(1'b1);
            @(negedge clk);
            dec_valid = 1'b0;
            compare("R8 b2b second", e1);
        end
        // Random mix: R1 R2 R3 R4 R5 R6 R7 R9
        for (int n = 0; n < 400; n++) begin
            if ($urandom % 4 != 0) set_match();
            else begin
                cp_num = 4'($urandom); op1 = 3'($urandom); crn = 4'($urandom);
                crm = 4'($urandom); op2 = 3'($urandom);
            end
            set_ctl(2'($urandom), 1'($urandom), 1'($urandom), 3'($urandom), 3'($urandom));
            src_val = $urandom;
            decode("R7 R9 random");
        end
        finish_run();
    end
endmodule